// File: doc/BRIEF.md
# Host Command/Reply Port Interface

This block sits on the device side of a host link. A host processor reaches it through single-cycle 32-bit register reads and writes. The host posts work by writing the bus address of a command into a request queue. A controller model on the device side drains that queue. When the controller finishes a command, it pushes the command's address into a reply queue. The host reads replies back, one entry at a time.

The host can detect flow-control conditions by reading the ports themselves. A read of the request port tells the host whether there is room. A read of the reply port returns all-ones when no reply is waiting, and no separate empty flag exists. A reply stays at the head of the queue until the host acknowledges it by writing zero to the reply port. One interrupt line signals that replies are waiting. Its enable register uses inverted polarity: writing bit 3 set turns the interrupt off, and writing zero turns it on.

Top module: `hcr_port`

## Requirements
- R1: A host write to offset 0x40 pushes the 32-bit write data into the request queue. The device side sees entries in arrival order on `dev_req_data`, with `dev_req_valid` high while the queue is non-empty, and removes the head with `dev_req_pop`.
- R2: A host read of offset 0x40 returns 0 while the request queue has room, and returns 1 when it holds DEPTH entries.
- R3: A host write to offset 0x40 while the request queue is full is discarded. It sets a sticky overflow flag, bit 1 of the status register at offset 0x30, which only reset clears.
- R4: A host read of offset 0x44 returns 0xFFFFFFFF when the reply queue is empty.
- R5: A host read of offset 0x44 returns the oldest reply when one is waiting. Repeated reads return the same entry and do not advance the queue.
- R6: A host write of 0 to offset 0x44 removes the head reply. A nonzero write to that offset, or any write to it while the queue is empty, changes nothing.
- R7: The mask register at offset 0x34 stores only bit 3 of the write data. Bit 3 set disables the interrupt, and bit 3 clear enables it. The register resets to 0x08 and reads back as 0x08 or 0.
- R8: Bit 0 of the status register reads 1 exactly when the reply queue is non-empty, whatever the mask setting.
- R9: `irq` is high exactly when the reply queue is non-empty and the mask register holds 0.
- R10: Read data appears on `host_rdata` with `host_rvalid` high in the cycle after the read is presented. Unmapped offsets read as 0, and writes to them have no effect.
- R11: A device push into a full reply queue is discarded. `dev_rsp_ready` is low exactly while the reply queue is full.
- R12: After reset, both queues are empty, the overflow flag is clear, the mask reads 0x08, and `irq` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| arst_n | input | 1 | Asynchronous active-low reset |
| host_valid | input | 1 | Host access strobe |
| host_we | input | 1 | 1 = write, 0 = read |
| host_addr | input | ADDR_W | Register byte offset |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Registered read data |
| host_rvalid | output | 1 | Read data valid |
| dev_req_pop | input | 1 | Device removes request head |
| dev_req_data | output | 32 | Request queue head |
| dev_req_valid | output | 1 | Request queue non-empty |
| dev_rsp_push | input | 1 | Device pushes a reply |
| dev_rsp_data | input | 32 | Reply command address |
| dev_rsp_ready | output | 1 | Reply queue has room |
| irq | output | 1 | Reply interrupt |

## Verification
The bench fills the request queue to the limit and writes one entry past it. A design that overwrote an entry or wrapped its pointer would deliver the rejected word, or lose an older one, when the device drains the queue. Reply reads are repeated without an acknowledgement, and nonzero or empty-queue acknowledgements are issued. A design that popped on read or on any write would show the second entry too early, and an unguarded pop would corrupt later data. The mask is driven through both polarities and through a value with bit 3 clear among other set bits. A conventional-polarity design would raise the interrupt while it should be masked.

// File: rtl/hcr_pkg.sv
package hcr_pkg;
  localparam int WORD_W = 32;
  localparam logic [7:0] OFS_STAT = 8'h30;
  localparam logic [7:0] OFS_MASK = 8'h34;
  localparam logic [7:0] OFS_REQ  = 8'h40;
  localparam logic [7:0] OFS_RSP  = 8'h44;
  localparam int MASK_BIT = 3;
  localparam logic [WORD_W-1:0] NO_REPLY = '1;
endpackage

// File: rtl/hcr_rst_sync.sv
module hcr_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= 2'b00;
    else         sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n = sync_q[1];
endmodule

// File: rtl/hcr_fifo.sv
module hcr_fifo #(
  parameter int DW    = 32,
  parameter int DEPTH = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [DW-1:0] din,
  input  logic          pop,
  output logic [DW-1:0] dout,
  output logic          full,
  output logic          empty
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wr_q, wr_d, rd_q, rd_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          do_push, do_pop;

  assign full    = (cnt_q == CW'(DEPTH));
  assign empty   = (cnt_q == '0);
  assign do_push = push & ~full;
  assign do_pop  = pop & ~empty;
  assign dout    = mem[rd_q];

  always_comb begin
    wr_d = wr_q;
    rd_d = rd_q;
    if (do_push) wr_d = (wr_q == AW'(DEPTH - 1)) ? '0 : wr_q + AW'(1);
    if (do_pop)  rd_d = (rd_q == AW'(DEPTH - 1)) ? '0 : rd_q + AW'(1);
    case ({do_push, do_pop})
      2'b10:   cnt_d = cnt_q + CW'(1);
      2'b01:   cnt_d = cnt_q - CW'(1);
      default: cnt_d = cnt_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      wr_q  <= wr_d;
      rd_q  <= rd_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_q] <= din;
  end
endmodule

// File: rtl/hcr_host_regs.sv
module hcr_host_regs
  import hcr_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_valid,
  input  logic              host_we,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [WORD_W-1:0] host_wdata,
  input  logic              req_full,
  input  logic              rsp_empty,
  input  logic [WORD_W-1:0] rsp_head,
  output logic              req_push,
  output logic              rsp_pop,
  output logic              ovf,
  output logic              mask_off,
  output logic [WORD_W-1:0] host_rdata,
  output logic              host_rvalid
);
  logic wr, rd, hit_req, hit_rsp, hit_stat, hit_mask;
  logic ovf_d, mask_d, rvalid_d;
  logic [WORD_W-1:0] rdata_d;

  assign wr       = host_valid & host_we;
  assign rd       = host_valid & ~host_we;
  assign hit_req  = (host_addr == ADDR_W'(OFS_REQ));
  assign hit_rsp  = (host_addr == ADDR_W'(OFS_RSP));
  assign hit_stat = (host_addr == ADDR_W'(OFS_STAT));
  assign hit_mask = (host_addr == ADDR_W'(OFS_MASK));

  assign req_push = wr & hit_req & ~req_full;
  assign rsp_pop  = wr & hit_rsp & (host_wdata == '0) & ~rsp_empty;

  always_comb begin
    ovf_d    = ovf | (wr & hit_req & req_full);
    mask_d   = (wr & hit_mask) ? host_wdata[MASK_BIT] : mask_off;
    rvalid_d = rd;
    rdata_d  = host_rdata;
    if (rd) begin
      if (hit_req)       rdata_d = {{(WORD_W-1){1'b0}}, req_full};
      else if (hit_rsp)  rdata_d = rsp_empty ? NO_REPLY : rsp_head;
      else if (hit_stat) rdata_d = {{(WORD_W-2){1'b0}}, ovf, ~rsp_empty};
      else if (hit_mask) rdata_d = {{(WORD_W-MASK_BIT-1){1'b0}}, mask_off, {MASK_BIT{1'b0}}};
      else               rdata_d = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ovf         <= 1'b0;
      mask_off    <= 1'b1;
      host_rdata  <= '0;
      host_rvalid <= 1'b0;
    end else begin
      ovf         <= ovf_d;
      mask_off    <= mask_d;
      host_rdata  <= rdata_d;
      host_rvalid <= rvalid_d;
    end
  end
endmodule

// File: rtl/hcr_port.sv
module hcr_port
  import hcr_pkg::*;
#(
  parameter int DEPTH  = 8,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              arst_n,
  input  logic              host_valid,
  input  logic              host_we,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [31:0]       host_wdata,
  output logic [31:0]       host_rdata,
  output logic              host_rvalid,
  input  logic              dev_req_pop,
  output logic [31:0]       dev_req_data,
  output logic              dev_req_valid,
  input  logic              dev_rsp_push,
  input  logic [31:0]       dev_rsp_data,
  output logic              dev_rsp_ready,
  output logic              irq
);
  logic rst_n_s;
  logic req_push, req_full, req_empty;
  logic rsp_pop, rsp_full, rsp_empty;
  logic ovf, mask_off;
  logic [WORD_W-1:0] rsp_head;

  hcr_rst_sync u_rst (.clk(clk), .arst_n(arst_n), .rst_n(rst_n_s));

  hcr_fifo #(.DW(WORD_W), .DEPTH(DEPTH)) u_req_q (
    .clk(clk), .rst_n(rst_n_s),
    .push(req_push), .din(host_wdata),
    .pop(dev_req_pop), .dout(dev_req_data),
    .full(req_full), .empty(req_empty)
  );

  hcr_fifo #(.DW(WORD_W), .DEPTH(DEPTH)) u_rsp_q (
    .clk(clk), .rst_n(rst_n_s),
    .push(dev_rsp_push), .din(dev_rsp_data),
    .pop(rsp_pop), .dout(rsp_head),
    .full(rsp_full), .empty(rsp_empty)
  );

  hcr_host_regs #(.ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst_n(rst_n_s),
    .host_valid(host_valid), .host_we(host_we),
    .host_addr(host_addr), .host_wdata(host_wdata),
    .req_full(req_full), .rsp_empty(rsp_empty), .rsp_head(rsp_head),
    .req_push(req_push), .rsp_pop(rsp_pop),
    .ovf(ovf), .mask_off(mask_off),
    .host_rdata(host_rdata), .host_rvalid(host_rvalid)
  );

  assign dev_req_valid = ~req_empty;
  assign dev_rsp_ready = ~rsp_full;
  assign irq           = ~rsp_empty & ~mask_off;
endmodule

// File: rtl/hcr_port_chk.sv
module hcr_port_chk
  import hcr_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              host_valid,
  input logic              host_we,
  input logic [ADDR_W-1:0] host_addr,
  input logic [31:0]       host_rdata,
  input logic              host_rvalid,
  input logic              irq,
  input logic              rsp_empty,
  input logic              mask_off,
  input logic              req_full,
  input logic              ovf,
  input logic [31:0]       rsp_head,
  input logic              rsp_pop
);
  logic rd;
  assign rd = host_valid & ~host_we;

  p_irq_gate_r9: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (!rsp_empty && !mask_off));

  p_ovf_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ovf |=> ovf);

  p_empty_ones_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && host_addr == ADDR_W'(OFS_RSP) && rsp_empty) |=> (host_rdata == NO_REPLY));

  p_head_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!rsp_empty && !rsp_pop) |=> $stable(rsp_head));

  p_req_room_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && host_addr == ADDR_W'(OFS_REQ)) |=> (host_rdata == {31'b0, $past(req_full)}));

  p_rvalid_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rd |=> host_rvalid);
endmodule

bind hcr_port hcr_port_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n_s),
  .host_valid(host_valid), .host_we(host_we), .host_addr(host_addr),
  .host_rdata(host_rdata), .host_rvalid(host_rvalid), .irq(irq),
  .rsp_empty(rsp_empty), .mask_off(mask_off), .req_full(req_full),
  .ovf(ovf), .rsp_head(rsp_head), .rsp_pop(rsp_pop)
);

// File: tb/hcr_port_tb.sv
module hcr_port_tb;
  localparam int DEPTH = 8;

  logic        clk = 1'b0;
  logic        arst_n = 1'b0;
  logic        host_valid = 1'b0, host_we = 1'b0;
  logic [7:0]  host_addr = '0;
  logic [31:0] host_wdata = '0;
  logic [31:0] host_rdata;
  logic        host_rvalid;
  logic        dev_req_pop = 1'b0;
  logic [31:0] dev_req_data;
  logic        dev_req_valid;
  logic        dev_rsp_push = 1'b0;
  logic [31:0] dev_rsp_data = '0;
  logic        dev_rsp_ready;
  logic        irq;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  hcr_port #(.DEPTH(DEPTH), .ADDR_W(8)) u_dut (
    .clk(clk), .arst_n(arst_n),
    .host_valid(host_valid), .host_we(host_we), .host_addr(host_addr),
    .host_wdata(host_wdata), .host_rdata(host_rdata), .host_rvalid(host_rvalid),
    .dev_req_pop(dev_req_pop), .dev_req_data(dev_req_data), .dev_req_valid(dev_req_valid),
    .dev_rsp_push(dev_rsp_push), .dev_rsp_data(dev_rsp_data), .dev_rsp_ready(dev_rsp_ready),
    .irq(irq)
  );

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic host_wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    host_valid = 1'b1; host_we = 1'b1; host_addr = a; host_wdata = d;
    @(negedge clk);
    host_valid = 1'b0; host_we = 1'b0;
  endtask

  task automatic host_rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    host_valid = 1'b1; host_we = 1'b0; host_addr = a;
    @(negedge clk);
    host_valid = 1'b0;
    d = host_rdata;
    chk("R10 rvalid", {31'b0, host_rvalid}, 32'd1);
  endtask

  task automatic dev_pop();
    @(negedge clk); dev_req_pop = 1'b1;
    @(negedge clk); dev_req_pop = 1'b0;
  endtask

  task automatic dev_push(input logic [31:0] d);
    @(negedge clk); dev_rsp_push = 1'b1; dev_rsp_data = d;
    @(negedge clk); dev_rsp_push = 1'b0;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    chk("R12 req empty", {31'b0, dev_req_valid}, 32'd0);
    chk("R12 rsp room", {31'b0, dev_rsp_ready}, 32'd1);
    chk("R12 irq low", {31'b0, irq}, 32'd0);
    host_rd(8'h30, d); chk("R12 status", d, 32'd0);
    host_rd(8'h34, d); chk("R12 mask", d, 32'h8);
    @(negedge clk);
    chk("R10 rvalid idle", {31'b0, host_rvalid}, 32'd0);
  endtask

  task automatic t_req_order();
    logic [31:0] d;
    host_rd(8'h40, d); chk("R2 room", d, 32'd0);
    for (int i = 0; i < 3; i++) host_wr(8'h40, 32'h1000_0000 + i * 32'h40);
    for (int i = 0; i < 3; i++) begin
      chk("R1 valid", {31'b0, dev_req_valid}, 32'd1);
      chk("R1 order", dev_req_data, 32'h1000_0000 + i * 32'h40);
      dev_pop();
    end
    chk("R1 drained", {31'b0, dev_req_valid}, 32'd0);
  endtask

  task automatic t_req_full();
    logic [31:0] d;
    for (int i = 0; i < DEPTH; i++) host_wr(8'h40, 32'hA000_0000 + i);
    host_rd(8'h40, d); chk("R2 full", d, 32'd1);
    host_rd(8'h30, d); chk("R3 no ovf yet", d & 32'h2, 32'd0);
    host_wr(8'h40, 32'hDEAD_BEEF);
    host_rd(8'h30, d); chk("R3 ovf set", d & 32'h2, 32'h2);
    for (int i = 0; i < DEPTH; i++) begin
      chk("R3 kept", dev_req_data, 32'hA000_0000 + i);
      dev_pop();
    end
    chk("R3 no extra", {31'b0, dev_req_valid}, 32'd0);
    host_rd(8'h40, d); chk("R2 room again", d, 32'd0);
    host_rd(8'h30, d); chk("R3 sticky", d & 32'h2, 32'h2);
  endtask

  task automatic t_rsp_ack();
    logic [31:0] d;
    host_rd(8'h44, d); chk("R4 empty ones", d, 32'hFFFF_FFFF);
    host_wr(8'h44, 32'd0);
    dev_push(32'h0000_1230);
    dev_push(32'h0000_4560);
    host_rd(8'h30, d); chk("R8 pending", d & 32'h1, 32'd1);
    host_rd(8'h44, d); chk("R5 head", d, 32'h0000_1230);
    host_rd(8'h44, d); chk("R5 reread", d, 32'h0000_1230);
    host_wr(8'h44, 32'd5);
    host_rd(8'h44, d); chk("R6 nonzero ignored", d, 32'h0000_1230);
    host_wr(8'h44, 32'd0);
    host_rd(8'h44, d); chk("R6 ack pops", d, 32'h0000_4560);
    host_wr(8'h44, 32'd0);
    host_rd(8'h44, d); chk("R4 empty again", d, 32'hFFFF_FFFF);
    host_rd(8'h30, d); chk("R8 not pending", d & 32'h1, 32'd0);
    host_wr(8'h44, 32'd0);
    dev_push(32'h0000_7890);
    host_rd(8'h44, d); chk("R6 empty ack harmless", d, 32'h0000_7890);
    host_wr(8'h44, 32'd0);
  endtask

  task automatic t_irq();
    logic [31:0] d;
    dev_push(32'h0000_0ABC);
    chk("R9 masked", {31'b0, irq}, 32'd0);
    host_rd(8'h30, d); chk("R8 pending masked", d & 32'h1, 32'd1);
    host_wr(8'h34, 32'd0);
    chk("R9 enabled", {31'b0, irq}, 32'd1);
    host_rd(8'h34, d); chk("R7 read 0", d, 32'd0);
    host_wr(8'h34, 32'h08);
    chk("R7 0x08 disables", {31'b0, irq}, 32'd0);
    host_rd(8'h34, d); chk("R7 read 8", d, 32'h8);
    host_wr(8'h34, 32'hFFFF_FFF7);
    chk("R7 bit3 only", {31'b0, irq}, 32'd1);
    host_rd(8'h34, d); chk("R7 stored bit", d, 32'd0);
    host_wr(8'h44, 32'd0);
    chk("R9 empty low", {31'b0, irq}, 32'd0);
    host_wr(8'h34, 32'h08);
  endtask

  task automatic t_rsp_full();
    logic [31:0] d;
    for (int i = 0; i < DEPTH; i++) dev_push(32'hC000_0000 + i);
    chk("R11 not ready", {31'b0, dev_rsp_ready}, 32'd0);
    dev_push(32'hBAD0_0000);
    for (int i = 0; i < DEPTH; i++) begin
      host_rd(8'h44, d); chk("R11 order", d, 32'hC000_0000 + i);
      host_wr(8'h44, 32'd0);
    end
    host_rd(8'h44, d); chk("R11 extra dropped", d, 32'hFFFF_FFFF);
    chk("R11 ready", {31'b0, dev_rsp_ready}, 32'd1);
  endtask

  task automatic t_unmapped();
    logic [31:0] d;
    host_rd(8'h30, d);
    host_wr(8'h10, 32'hFFFF_FFFF);
    host_rd(8'h10, d); chk("R10 unmapped zero", d, 32'd0);
    host_rd(8'h34, d); chk("R10 write ignored", d, 32'h8);
    chk("R10 no request", {31'b0, dev_req_valid}, 32'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    arst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_req_order();
    t_req_full();
    t_rsp_ack();
    t_irq();
    t_rsp_full();
    t_unmapped();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog got=timeout exp=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule